// File: doc/BRIEF.md
# Banked Secure/Nonsecure System Control Register

This block holds the processor's main system control word. It keeps two independent copies, one for the secure world and one for the nonsecure world. The copy that belongs to the current security state serves each access and drives the enable outputs. Those outputs switch the MMU, strict alignment checking, data caching, instruction caching and program flow prediction. A further output selects the high exception vectors.

Requests come in as one-cycle strobes. Each strobe carries a read/write flag, write data and a privilege flag, and the security state is a separate level input. A read returns the packed word in the same cycle. A write updates the active copy at the next clock edge.

An access from user mode is refused with a one-cycle undefined-instruction fault. A secure privileged write is also refused while the secure write-lock input is high. Reserved bits are fixed: some read as one and the rest read as zero. The high-vectors bit of both copies takes its reset value from a strap input. The block also computes the exception vector base for the active world.

Top module: `sysctl_bank`

## Requirements
- R1: On a synchronous active-high reset, both copies clear the MMU, alignment, data cache, flow prediction and instruction cache enables to 0. Both copies load their high-vectors bit from `strap_hivec`.
- R2: A privileged accepted write stores these fields of the active copy, and a read returns them at the same positions: bit 0 MMU enable, bit 1 alignment check, bit 2 data cache, bit 11 flow prediction, bit 12 instruction cache, bit 13 high vectors.
- R3: Bits [6:3] always read as 1. Bits [10:7] and [31:14] always read as 0. Writing those bits has no effect on any later read.
- R4: `sec_state`=1 selects the secure copy and 0 selects the nonsecure copy. Writes change only the selected copy. The enable outputs always reflect the selected copy.
- R5: A request with `req_priv`=0 raises `undef_fault`, returns `rd_data`=0 and leaves both copies unchanged, whether it is a read or a write, in either security state.
- R6: A secure privileged write while `sec_wr_lock`=1 raises `undef_fault` and leaves the secure copy unchanged.
- R7: `sec_wr_lock` has no effect on nonsecure privileged writes. A privileged read never faults.
- R8: `undef_fault` is asserted only in a cycle where `req_valid` is high. It is never asserted when no request is present.
- R9: `vec_base` is 0xFFFF0000 when the active copy's high-vectors bit is 1. Otherwise it equals `vbar_sec` in the secure state and `vbar_nsec` in the nonsecure state.
- R10: `strap_hivec` is sampled only during reset. Changing it afterwards does not change either copy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_hivec | input | 1 | Reset value of the high-vectors bit |
| sec_state | input | 1 | Current security state, 1 = secure |
| req_valid | input | 1 | Access request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_priv | input | 1 | 1 = privileged mode, 0 = user mode |
| req_wdata | input | 32 | Write data |
| sec_wr_lock | input | 1 | Blocks secure writes when high |
| vbar_sec | input | 32 | Secure vector base address |
| vbar_nsec | input | 32 | Nonsecure vector base address |
| rd_data | output | 32 | Read data, combinational, 0 when faulted or idle |
| undef_fault | output | 1 | Undefined-instruction fault, same cycle as request |
| mmu_en | output | 1 | MMU enable of the active copy |
| align_chk | output | 1 | Strict alignment check of the active copy |
| dcache_en | output | 1 | Data cache enable of the active copy |
| flowpred_en | output | 1 | Flow prediction enable of the active copy |
| icache_en | output | 1 | Instruction cache enable of the active copy |
| hivec_en | output | 1 | High-vectors select of the active copy |
| vec_base | output | 32 | Selected exception vector base |

## Verification
The hardest situation to reach is a state where the two copies hold different values and one of them has just been the target of a refused write. Only then can a faulted or misrouted write be told apart from a correct one. The bench first writes distinct patterns into each copy. It then issues user-mode and locked secure writes of all-ones data, and reads both copies back by switching `sec_state`. The strap check holds reset low after a reset with the strap at 0, raises the strap for several cycles and then reads the high-vectors bit.

// File: rtl/sysctl_bank.sv
module sysctl_bank #(
  parameter logic [31:0] HIVEC_BASE = 32'hFFFF_0000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        strap_hivec,
  input  logic        sec_state,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic        req_priv,
  input  logic [31:0] req_wdata,
  input  logic        sec_wr_lock,
  input  logic [31:0] vbar_sec,
  input  logic [31:0] vbar_nsec,
  output logic [31:0] rd_data,
  output logic        undef_fault,
  output logic        mmu_en,
  output logic        align_chk,
  output logic        dcache_en,
  output logic        flowpred_en,
  output logic        icache_en,
  output logic        hivec_en,
  output logic [31:0] vec_base
);
  localparam int NBANK = 2;
  localparam int NFLD  = 6;

  // field order in a bank: {hivec, icache, flowpred, dcache, align, mmu}
  logic [NFLD-1:0] bank_q [NBANK];
  logic [NFLD-1:0] act_f;
  logic [NFLD-1:0] wr_f;
  logic            wr_ok;
  logic [NFLD-1:0] bank_s, bank_ns;

  assign undef_fault = req_valid & (~req_priv | (req_write & sec_state & sec_wr_lock));
  assign wr_ok       = req_valid & req_write & ~undef_fault;
  assign wr_f        = {req_wdata[13], req_wdata[12], req_wdata[11],
                        req_wdata[2], req_wdata[1], req_wdata[0]};

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst)
        bank_q[b] <= {strap_hivec, {(NFLD-1){1'b0}}};
      else if (wr_ok && (sec_state == b[0]))
        bank_q[b] <= wr_f;
    end
  end

  assign bank_s  = bank_q[1];
  assign bank_ns = bank_q[0];
  assign act_f   = sec_state ? bank_s : bank_ns;

  assign rd_data = (req_valid && !req_write && !undef_fault)
                 ? {18'b0, act_f[5:3], 4'b0000, 4'b1111, act_f[2:0]}
                 : 32'b0;

  assign mmu_en      = act_f[0];
  assign align_chk   = act_f[1];
  assign dcache_en   = act_f[2];
  assign flowpred_en = act_f[3];
  assign icache_en   = act_f[4];
  assign hivec_en    = act_f[5];
  assign vec_base    = act_f[5] ? HIVEC_BASE : (sec_state ? vbar_sec : vbar_nsec);
endmodule

module sysctl_bank_chk (
  input logic        clk,
  input logic        rst,
  input logic        sec_state,
  input logic        req_valid,
  input logic        req_write,
  input logic        req_priv,
  input logic        sec_wr_lock,
  input logic [31:0] rd_data,
  input logic        undef_fault,
  input logic        hivec_en,
  input logic [31:0] vec_base,
  input logic [5:0]  bank_s,
  input logic [5:0]  bank_ns
);
  AST_RSV_BITS: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && !undef_fault) |-> (rd_data[6:3] == 4'hF && rd_data[10:7] == 4'h0 && rd_data[31:14] == 18'h0)); // R3
  AST_NS_WR_KEEPS_S: assert property (@(posedge clk) disable iff (rst)
    (!sec_state) |=> $stable(bank_s)); // R4
  AST_USER_FAULT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_priv) |-> (undef_fault && rd_data == 32'h0)); // R5
  AST_USER_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_priv) |=> ($stable(bank_s) && $stable(bank_ns))); // R5
  AST_LOCK_FAULT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && req_priv && sec_state && sec_wr_lock) |-> undef_fault); // R6
  AST_LOCK_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
    (sec_state && sec_wr_lock) |=> $stable(bank_s)); // R6
  AST_PRIV_READ_OK: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_priv && !req_write) |-> !undef_fault); // R7
  AST_IDLE_NO_FAULT: assert property (@(posedge clk) disable iff (rst)
    (!req_valid) |-> !undef_fault); // R8
  AST_HIVEC_BASE: assert property (@(posedge clk) disable iff (rst)
    hivec_en |-> (vec_base == 32'hFFFF_0000)); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!req_valid) |=> ($stable(bank_s) && $stable(bank_ns))); // R10
endmodule

bind sysctl_bank sysctl_bank_chk u_chk (
  .clk(clk), .rst(rst), .sec_state(sec_state), .req_valid(req_valid),
  .req_write(req_write), .req_priv(req_priv), .sec_wr_lock(sec_wr_lock),
  .rd_data(rd_data), .undef_fault(undef_fault), .hivec_en(hivec_en),
  .vec_base(vec_base), .bank_s(bank_s), .bank_ns(bank_ns)
);

// File: tb/tb_sysctl_bank.sv
module tb_sysctl_bank;
  logic        clk = 0;
  logic        rst = 1;
  logic        strap_hivec = 0;
  logic        sec_state = 1;
  logic        req_valid = 0;
  logic        req_write = 0;
  logic        req_priv = 1;
  logic [31:0] req_wdata = 0;
  logic        sec_wr_lock = 0;
  logic [31:0] vbar_sec  = 32'h1000_0000;
  logic [31:0] vbar_nsec = 32'h2000_0040;
  logic [31:0] rd_data, vec_base;
  logic undef_fault, mmu_en, align_chk, dcache_en, flowpred_en, icache_en, hivec_en;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  sysctl_bank dut (.*);

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] word(input logic v, i, z, c, a, m);
    return {18'b0, v, i, z, 4'b0000, 4'b1111, c, a, m};
  endfunction

  task automatic access(input logic w, input logic [31:0] d, input logic sec,
                        input logic pr, input logic lk,
                        output logic [31:0] rd, output logic f);
    @(negedge clk);
    req_valid = 1; req_write = w; req_wdata = d; sec_state = sec;
    req_priv = pr; sec_wr_lock = lk;
    #1; rd = rd_data; f = undef_fault;
    @(posedge clk); #1;
    req_valid = 0; req_write = 0; req_priv = 1; sec_wr_lock = 0;
  endtask

  task automatic do_reset(input logic strap);
    @(negedge clk); rst = 1; strap_hivec = strap;
    @(negedge clk); @(negedge clk); rst = 0;
  endtask

  task automatic t_reset;
    logic [31:0] rd; logic f;
    do_reset(1);
    sec_state = 1; #1;
    chk("R1 enables cleared", {mmu_en, align_chk, dcache_en, flowpred_en, icache_en}, 0);
    chk("R9 hivec base", vec_base, 32'hFFFF_0000);
    access(0, 0, 1, 1, 0, rd, f); chk("R1 secure reset word strap=1", rd, word(1,0,0,0,0,0));
    access(0, 0, 0, 1, 0, rd, f); chk("R1 nonsecure reset word strap=1", rd, word(1,0,0,0,0,0));
    do_reset(0);
    access(0, 0, 1, 1, 0, rd, f); chk("R1 secure reset word strap=0", rd, word(0,0,0,0,0,0));
    access(0, 0, 0, 1, 0, rd, f); chk("R1 nonsecure reset word strap=0", rd, word(0,0,0,0,0,0));
  endtask

  task automatic t_fields;
    logic [31:0] rd; logic f;
    access(1, 32'hFFFF_FFFF, 1, 1, 0, rd, f);
    chk("R2 write fault", f, 0);
    chk("R2 outputs all set", {mmu_en, align_chk, dcache_en, flowpred_en, icache_en, hivec_en}, 6'h3F);
    access(0, 0, 1, 1, 0, rd, f); chk("R2 R3 all-ones readback", rd, 32'h0000_387F);
    access(1, 32'hFFFF_C780, 1, 1, 0, rd, f);
    access(0, 0, 1, 1, 0, rd, f); chk("R3 reserved writes ignored", rd, 32'h0000_0078);
    access(0, 0, 1, 1, 0, rd, f); chk("R2 read no fault", f, 0);
  endtask

  task automatic t_banking;
    logic [31:0] rd; logic f;
    access(1, 32'h0000_1005, 1, 1, 0, rd, f);
    access(0, 0, 0, 1, 0, rd, f); chk("R4 nonsecure untouched", rd, word(0,0,0,0,0,0));
    access(1, 32'h0000_0802, 0, 1, 0, rd, f);
    access(0, 0, 0, 1, 0, rd, f); chk("R4 nonsecure written", rd, word(0,0,1,0,1,0));
    access(0, 0, 1, 1, 0, rd, f); chk("R4 secure kept", rd, word(0,1,0,1,0,1));
    sec_state = 1; #1;
    chk("R4 secure outputs", {hivec_en, icache_en, flowpred_en, dcache_en, align_chk, mmu_en}, 6'b010101);
    sec_state = 0; #1;
    chk("R4 nonsecure outputs", {hivec_en, icache_en, flowpred_en, dcache_en, align_chk, mmu_en}, 6'b001010);
  endtask

  task automatic t_user;
    logic [31:0] rd; logic f;
    access(1, 32'hFFFF_FFFF, 1, 0, 0, rd, f); chk("R5 user write secure faults", f, 1);
    access(1, 32'hFFFF_FFFF, 0, 0, 0, rd, f); chk("R5 user write nonsecure faults", f, 1);
    access(0, 0, 1, 0, 0, rd, f);
    chk("R5 user read faults", f, 1); chk("R5 user read data zero", rd, 0);
    access(0, 0, 1, 1, 0, rd, f); chk("R5 secure unchanged", rd, word(0,1,0,1,0,1));
    access(0, 0, 0, 1, 0, rd, f); chk("R5 nonsecure unchanged", rd, word(0,0,1,0,1,0));
  endtask

  task automatic t_lock;
    logic [31:0] rd; logic f;
    access(1, 32'hFFFF_FFFF, 1, 1, 1, rd, f); chk("R6 locked secure write faults", f, 1);
    access(0, 0, 1, 1, 1, rd, f);
    chk("R7 privileged read under lock", f, 0);
    chk("R6 secure copy unchanged", rd, word(0,1,0,1,0,1));
    access(1, 32'h0000_2000, 0, 1, 1, rd, f); chk("R7 nonsecure write under lock", f, 0);
    access(0, 0, 0, 1, 1, rd, f); chk("R7 nonsecure updated", rd, word(1,0,0,0,0,0));
    sec_state = 0; #1; chk("R9 nonsecure hivec base", vec_base, 32'hFFFF_0000);
    sec_state = 1; #1; chk("R9 secure external base", vec_base, vbar_sec);
    access(1, 32'h0, 0, 1, 0, rd, f);
    sec_state = 0; #1; chk("R9 nonsecure external base", vec_base, vbar_nsec);
  endtask

  task automatic t_pulse;
    logic [31:0] rd; logic f;
    access(0, 0, 1, 0, 0, rd, f); chk("R8 fault in request cycle", f, 1);
    #1; chk("R8 fault released after request", undef_fault, 0);
    @(negedge clk); req_priv = 0; req_write = 1; #1;
    chk("R8 no fault without valid", undef_fault, 0);
    req_priv = 1; req_write = 0;
  endtask

  task automatic t_strap;
    logic [31:0] rd; logic f;
    do_reset(0);
    strap_hivec = 1;
    repeat (4) @(negedge clk);
    access(0, 0, 1, 1, 0, rd, f); chk("R10 secure ignores strap", rd, word(0,0,0,0,0,0));
    access(0, 0, 0, 1, 0, rd, f); chk("R10 nonsecure ignores strap", rd, word(0,0,0,0,0,0));
  endtask

  initial begin
    t_reset;
    t_fields;
    t_banking;
    t_user;
    t_lock;
    t_pulse;
    t_strap;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule